// File: doc/BRIEF.md
# Packed Integer Lane Width Converter

This block reinterprets a wide vector of packed integer lanes at a different element width. The source and destination widths are each picked from 8, 16, 32 and 64 bits, and each side is marked signed or unsigned. The number of lanes on either side is the vector width divided by that side's element width.

Widening reads one source lane per destination lane and extends it by the source signedness. Narrowing keeps the low bits of each source value, or, when saturation is enabled, first clamps the value to the destination range. A one-bit part select chooses between the even and odd positions. When narrowing, it picks the slot a result occupies within its group of destination lanes. When widening, it picks which source lane of each group is read.

A per-source-lane enable forces disabled lanes to zero. An unsupported width pair raises a flag and yields an all-zero vector. The conversion is combinational and feeds a single output register, so results appear one clock after the inputs.

Top module: `int_lane_conv`

## Requirements
- R1: While reset is asserted and after its release, before the first conversion, `vout` is all zeros and `bad_pair` is 0.
- R2: Results are registered. `vout` and `bad_pair` change only at a rising clock edge and reflect the inputs present at that edge.
- R3: Width codes are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. A sign bit of 1 means signed. A side of width W holds VEC_W/W lanes, and lane k occupies bits k*W and up.
- R4: When widening by ratio R = Wd/Ws, destination lane j takes source lane j*R + part_odd. The value is sign-extended if `src_sgn` is 1 and zero-extended otherwise. `sat_en` has no effect.
- R5: When narrowing by ratio R = Ws/Wd, source lane g goes to destination lane g*R + part_odd. The other destination lanes of that group read zero. With `sat_en` at 0, the low Wd bits are kept, so the value wraps.
- R6: When narrowing with `sat_en` at 1, values are clamped to the destination range. For a signed destination the range is -2^(Wd-1) to 2^(Wd-1)-1; for an unsigned destination it is 0 to 2^Wd-1. A negative signed source therefore gives 0 for an unsigned destination, and an unsigned source above 32767 gives 32767 for a signed 16-bit destination.
- R7: `lane_en[k]` gates source lane k. A destination lane whose source lane has its bit cleared reads zero.
- R8: A 64-bit source, or equal source and destination widths, is illegal. This sets `bad_pair` to 1 and drives `vout` to all zeros. A legal pair gives `bad_pair` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_wid | input | 2 | Source element width code |
| src_sgn | input | 1 | Source is signed |
| dst_wid | input | 2 | Destination element width code |
| dst_sgn | input | 1 | Destination is signed |
| sat_en | input | 1 | Clamp on narrowing |
| part_odd | input | 1 | Part select: 0 even, 1 odd |
| lane_en | input | VEC_W/8 | One enable per source lane |
| vin | input | VEC_W | Source vector |
| vout | output | VEC_W | Converted vector, registered |
| bad_pair | output | 1 | Unsupported width pair, registered |

## Verification
The bench builds the block with VEC_W = 256 rather than the default 2048. At that width, the widest ratio (8 to 64 bits) still spans four destination lanes, and every lane and every group boundary of every width pair is compared in each vector against a bench model. The smaller vector lets several hundred random mode, mask and data mixes cover every ordered width pair, both part selects and both saturation settings. Directed vectors pin the clamp extremes, wrap-around, part placement, masking and illegal pairs.

// File: rtl/int_lane_conv.sv
module int_lane_conv #(
  parameter int VEC_W = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         src_wid,
  input  logic               src_sgn,
  input  logic [1:0]         dst_wid,
  input  logic               dst_sgn,
  input  logic               sat_en,
  input  logic               part_odd,
  input  logic [VEC_W/8-1:0] lane_en,
  input  logic [VEC_W-1:0]   vin,
  output logic [VEC_W-1:0]   vout,
  output logic               bad_pair
);

  function automatic logic [33:0] ext_lane(input logic [31:0] raw, input int ws, input logic sgn);
    logic [33:0] r;
    r = '0;
    for (int b = 0; b < 34; b++)
      r[b] = (b < ws) ? raw[b] : (sgn & raw[ws-1]);
    return r;
  endfunction

  function automatic logic [63:0] fit(input logic signed [33:0] v, input int wd,
                                      input logic dsgn, input logic clamp);
    logic signed [33:0] lo, hi, c;
    logic [63:0] r;
    hi = dsgn ? (34'sd1 <<< (wd - 1)) - 34'sd1 : (34'sd1 <<< wd) - 34'sd1;
    lo = dsgn ? -(34'sd1 <<< (wd - 1)) : 34'sd0;
    c = v;
    if (clamp && v > hi) c = hi;
    else if (clamp && v < lo) c = lo;
    r = {{30{c[33]}}, c};
    for (int b = 0; b < 64; b++)
      if (b >= wd) r[b] = 1'b0;
    return r;
  endfunction

  logic [VEC_W-1:0] cand [4][3];

  for (genvar d = 0; d < 4; d++) begin : g_dst
    localparam int WD = 8 << d;
    localparam int LD = VEC_W / WD;
    for (genvar s = 0; s < 3; s++) begin : g_src
      localparam int WS = 8 << s;
      logic [VEC_W-1:0] pv;
      if (s == d) begin : g_same
        assign pv = '0;
      end else if (WS > WD) begin : g_nar
        localparam int R = WS / WD;
        for (genvar j = 0; j < LD; j++) begin : g_lane
          localparam int G = j / R;
          localparam int K = j % R;
          if (K < 2) begin : g_live
            assign pv[j*WD +: WD] = (lane_en[G] && (part_odd == (K == 1)))
              ? WD'(fit(ext_lane(32'(vin[G*WS +: WS]), WS, src_sgn), WD, dst_sgn, sat_en))
              : '0;
          end else begin : g_dead
            assign pv[j*WD +: WD] = '0;
          end
        end
      end else begin : g_wid
        localparam int R = WD / WS;
        for (genvar j = 0; j < LD; j++) begin : g_lane
          localparam int G0 = j * R;
          logic [WD-1:0] ev, od;
          assign ev = lane_en[G0]
            ? WD'(fit(ext_lane(32'(vin[G0*WS +: WS]), WS, src_sgn), WD, dst_sgn, 1'b0)) : '0;
          assign od = lane_en[G0+1]
            ? WD'(fit(ext_lane(32'(vin[(G0+1)*WS +: WS]), WS, src_sgn), WD, dst_sgn, 1'b0)) : '0;
          assign pv[j*WD +: WD] = part_odd ? od : ev;
        end
      end
      assign cand[d][s] = pv;
    end
  end

  logic legal;
  logic [VEC_W-1:0] nxt;
  assign legal = (src_wid != 2'd3) && (src_wid != dst_wid);

  always_comb begin
    nxt = '0;
    if (legal) begin
      case (src_wid)
        2'd0:    nxt = cand[dst_wid][0];
        2'd1:    nxt = cand[dst_wid][1];
        2'd2:    nxt = cand[dst_wid][2];
        default: nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout     <= '0;
      bad_pair <= 1'b0;
    end else begin
      vout     <= nxt;
      bad_pair <= !legal;
    end
  end

endmodule

// File: rtl/int_lane_conv_chk.sv
module int_lane_conv_chk #(
  parameter int VEC_W = 2048
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         src_wid,
  input logic               src_sgn,
  input logic [1:0]         dst_wid,
  input logic               dst_sgn,
  input logic               sat_en,
  input logic               part_odd,
  input logic [VEC_W/8-1:0] lane_en,
  input logic [VEC_W-1:0]   vin,
  input logic [VEC_W-1:0]   vout,
  input logic               bad_pair
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (vout == '0 && !bad_pair)); // R1

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pair |-> vout == '0); // R8

  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(src_wid == 2'd3 || src_wid == dst_wid) |-> bad_pair); // R8

  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(lane_en == '0) |-> vout == '0); // R7

  AST_EVEN_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(src_wid == 2'd1 && dst_wid == 2'd0 && !part_odd) |-> vout[15:8] == 8'd0); // R5

  AST_NEG_TO_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(sat_en && src_sgn && !dst_sgn && src_wid == 2'd2 && dst_wid == 2'd0 &&
          !part_odd && vin[31]) |-> vout[7:0] == 8'd0); // R6
endmodule

bind int_lane_conv int_lane_conv_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/int_lane_conv_test.sv
`timescale 1ns/1ps
module int_lane_conv_test;
  localparam int W  = 256;
  localparam int MW = W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_wid = 2'd0, dst_wid = 2'd1;
  logic src_sgn = 1'b0, dst_sgn = 1'b0, sat_en = 1'b0, part_odd = 1'b0;
  logic [MW-1:0] lane_en = '0;
  logic [W-1:0] vin = '0;
  logic [W-1:0] vout;
  logic bad_pair;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  int_lane_conv #(.VEC_W(W)) uut (.*);

  function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [MW-1:0] m,
      input logic [1:0] sw, input logic ss, input logic [1:0] dw, input logic ds,
      input logic st, input logic pt);
    logic [W-1:0] r;
    int ws, wd, rr, g;
    logic act;
    longint v, lo, hi;
    r = '0;
    if (sw == 2'd3 || sw == dw) return r;
    ws = 8 << sw;
    wd = 8 << dw;
    for (int j = 0; j < W / wd; j++) begin
      if (ws > wd) begin rr = ws / wd; g = j / rr; act = (j % rr == int'(pt)) && m[g]; end
      else begin rr = wd / ws; g = j * rr + int'(pt); act = m[g]; end
      v = 0;
      for (int b = 0; b < ws; b++) v[b] = x[g*ws+b];
      if (ss && v[ws-1]) v = v - (longint'(1) << ws);
      if (ws > wd && st) begin
        hi = ds ? (longint'(1) << (wd-1)) - 1 : (longint'(1) << wd) - 1;
        lo = ds ? -(longint'(1) << (wd-1)) : 0;
        if (v > hi) v = hi; else if (v < lo) v = lo;
      end
      if (act) for (int b = 0; b < wd; b++) r[j*wd+b] = v[b];
    end
    return r;
  endfunction

  task automatic check_vec(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_val(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] sw, input logic ss, input logic [1:0] dw,
      input logic ds, input logic st, input logic pt, input logic [MW-1:0] m, input logic [W-1:0] x);
    @(negedge clk);
    src_wid = sw; src_sgn = ss; dst_wid = dw; dst_sgn = ds;
    sat_en = st; part_odd = pt; lane_en = m; vin = x;
  endtask

  task automatic run(input string tag, input logic [1:0] sw, input logic ss, input logic [1:0] dw,
      input logic ds, input logic st, input logic pt, input logic [MW-1:0] m, input logic [W-1:0] x);
    drive(sw, ss, dw, ds, st, pt, m, x);
    @(negedge clk);
    check_vec(tag, vout, model(x, m, sw, ss, dw, ds, st, pt));
    check_val(tag, longint'(bad_pair), longint'(sw == 2'd3 || sw == dw));
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] x, held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_vec("R1 reset vout", vout, '0);
    check_val("R1 reset flag", longint'(bad_pair), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec("R1 after release", vout, '0);

    // R6: signed 32 -> unsigned 8 clamps -5 to 0 and 300 to 255, keeps 100
    x = '0;
    x[31:0] = 32'hFFFF_FFFB; x[63:32] = 32'd300; x[95:64] = 32'd100;
    run("R6 s32->u8 sat", 2'd2, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, '1, x);
    check_val("R6 neg to zero", longint'(vout[7:0]), 0);
    check_val("R6 big to 255", longint'(vout[39:32]), 255);
    check_val("R6 in range", longint'(vout[71:64]), 100);

    // R6: unsigned 32 -> signed 16 clamps to 32767
    x = '0; x[31:0] = 32'h0001_2345; x[63:32] = 32'hFFFF_FFFF;
    run("R6 u32->s16 sat", 2'd2, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, '1, x);
    check_val("R6 32767", longint'(vout[15:0]), 32767);
    check_val("R6 32767 top", longint'(vout[47:32]), 32767);

    // R5: wrap without saturation, odd placement
    x = '0; x[15:0] = 16'h1234; x[31:16] = 16'hFF80;
    run("R5 16->8 wrap odd", 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, '1, x);
    check_val("R5 odd slot", longint'(vout[15:8]), 'h34);
    check_val("R5 even slot zero", longint'(vout[7:0]), 0);

    // R4: widening sign extension ignores sat_en
    x = '0; x[7:0] = 8'hF0; x[15:8] = 8'h85;
    run("R4 s8->s32 sat on", 2'd0, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, '1, x);
    check_val("R4 sign ext", longint'(vout[31:0]), 'hFFFF_FF85);
    run("R4 u8->u64 odd", 2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, '1, x);
    check_val("R4 zero ext", longint'(vout[63:0]), 'h85);

    // R7: masking
    x = {W/32{32'hDEAD_BEEF}};
    run("R7 mask alt", 2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, {MW/2{2'b01}}, x);
    run("R7 mask none", 2'd1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, '0, x);
    check_vec("R7 all masked", vout, '0);

    // R8: illegal pairs
    run("R8 8->8", 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, '1, x);
    check_val("R8 flag", longint'(bad_pair), 1);
    run("R8 64 src", 2'd3, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, '1, x);
    check_vec("R8 zero", vout, '0);

    // R2: output holds until the edge
    x = {W/32{32'h0102_0304}};
    run("R2 first", 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, '1, x);
    held = vout;
    drive(2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, '1, x);
    #1;
    check_vec("R2 hold before edge", vout, held);
    @(negedge clk);
    check_vec("R2 after edge", vout, model(x, '1, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0));

    // R3: random mix over all width pairs
    for (int i = 0; i < 600; i++) begin
      logic [MW-1:0] m;
      for (int k = 0; k < W / 32; k++) x[k*32 +: 32] = $urandom;
      m = '0;
      for (int k = 0; k < MW; k++) m[k] = ($urandom % 4) != 0;
      run("R3 random", 2'($urandom % 4), 1'($urandom), 2'($urandom % 4), 1'($urandom),
          1'($urandom), 1'($urandom), m, x);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule